// File: doc/BRIEF.md
# Programmable Almost-Full/Almost-Empty Flag Controller

This block is the status logic placed beside a 256-word FIFO. It receives the FIFO's current occupancy from the pointer logic and turns it into two level indications: a combined near-boundary flag, raised when the FIFO is close to either empty or full, and a half-full flag. The two limits that define "close" are two 7-bit offsets: a low offset (near-empty) and a high offset (near-full). Both start at 32 after reset.

The offsets are loaded over the low seven bits of the FIFO write data bus, using the write-side clock and write strobe, while an active-low program-enable input is held low. Programming is only possible straight after reset. The first programming strobe loads both offsets with the same value. A second consecutive programming strobe rewrites only the high offset. The write strobes used for programming are kept out of the storage array through a write-inhibit output.

A small state machine tracks the programming window. Its states are `PS_OPEN`, `PS_SECOND` and `PS_LOCKED`:
- `PS_OPEN` is entered on reset; here no programming strobe has been seen yet.
- `PS_SECOND` is reached when a programming strobe is taken in `PS_OPEN` (the "both" transition). In this state one programming strobe has been taken.
- A second programming strobe moves `PS_SECOND` to `PS_LOCKED` (the "high-only" transition).
- A strobe with program-enable high moves `PS_OPEN` or `PS_SECOND` to `PS_LOCKED` (the "close" transition).
- `PS_LOCKED` is left only by reset.

Top module: `afae_flag_ctrl`

## Requirements
- R1: After reset both offsets are 32, the programming window is open, and with a word count of 0 the near-boundary flag is 1, the half-full flag is 0 and write-inhibit is 0.
- R2: The first strobe (`load_stb`=1 at a rising clock edge) with `prog_en_n`=0 inside an open window loads `din_lo[6:0]` into both the low and the high offset, and write-inhibit is 1 during that strobe cycle.
- R3: A programming strobe that directly follows the first one, with no non-programming strobe between them, rewrites only the high offset from `din_lo[6:0]` and leaves the low offset unchanged; write-inhibit is 1 during that strobe cycle.
- R4: A strobe with `prog_en_n`=1 closes the window until the next reset, and write-inhibit stays 0 for it. Later strobes with `prog_en_n`=0 are not inhibited and change neither offset.
- R5: After two programming strobes the window is closed: a third strobe with `prog_en_n`=0 is not inhibited and changes neither offset.
- R6: Write-inhibit is 0 in every cycle in which `load_stb` is 0 or `prog_en_n` is 1.
- R7: The near-boundary flag is 1 when `word_cnt` <= low offset or `word_cnt` >= 256 - high offset, and 0 for counts between low+1 and 255 - high. It follows `word_cnt` in the same cycle.
- R8: The half-full flag is 1 exactly when `word_cnt` >= 128, in the same cycle.
- R9: Cycles with `prog_en_n`=0 but `load_stb`=0 neither program an offset nor consume a programming step.
- R10: With the default offsets, the near-boundary flag changes between counts 32 and 33 and between counts 223 and 224.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side (load) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en_n | input | 1 | Active-low offset programming enable |
| load_stb | input | 1 | Write strobe; marks a load edge |
| din_lo | input | 7 | Low seven bits of the write data bus |
| word_cnt | input | 9 | Current FIFO occupancy, 0 to 256 |
| level_flag | output | 1 | Near-empty or near-full indication |
| half_flag | output | 1 | Occupancy at or above half depth |
| wr_block | output | 1 | Keeps the current strobe out of the storage array |

## Verification
The checker assumes that `word_cnt` never exceeds 256. It also assumes that `prog_en_n`, `load_stb` and `din_lo` change only between clock edges, so every strobe is seen as exactly one load edge. The bench drives all inputs on the falling clock edge and keeps the count inside 0..256, including at both ends of its sweeps. Under these assumptions the checker can follow the programming window from the strobes alone, and can tie the flag ends to the fixed counts 0 and 256.

// File: rtl/afae_pkg.sv
package afae_pkg;
    typedef enum logic [1:0] {
        PS_OPEN   = 2'd0,
        PS_SECOND = 2'd1,
        PS_LOCKED = 2'd2
    } prog_state_e;
endpackage

// File: rtl/afae_prog_fsm.sv
module afae_prog_fsm
    import afae_pkg::*;
#(
    parameter int OFS_W   = 7,
    parameter int DEF_OFS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en_n,
    input  logic             load_stb,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] ofs_lo,
    output logic [OFS_W-1:0] ofs_hi,
    output logic             wr_block
);
    localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

    prog_state_e state_q, state_d;
    logic        prog_edge;
    logic        close_edge;

    assign prog_edge  = load_stb && !prog_en_n;
    assign close_edge = load_stb && prog_en_n;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OPEN: begin
                if (prog_edge)       state_d = PS_SECOND;
                else if (close_edge) state_d = PS_LOCKED;
            end
            PS_SECOND: begin
                if (load_stb)        state_d = PS_LOCKED;
            end
            PS_LOCKED:               state_d = PS_LOCKED;
            default:                 state_d = PS_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_OPEN;
        else        state_q <= state_d;
    end

    // offset registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_lo <= DEF_V;
            ofs_hi <= DEF_V;
        end else if (prog_edge) begin
            if (state_q == PS_OPEN) begin
                ofs_lo <= din;
                ofs_hi <= din;
            end else if (state_q == PS_SECOND) begin
                ofs_hi <= din;
            end
        end
    end

    // outputs
    always_comb begin
        wr_block = 1'b0;
        unique case (state_q)
            PS_OPEN, PS_SECOND: wr_block = prog_edge;
            PS_LOCKED:          wr_block = 1'b0;
            default:            wr_block = 1'b0;
        endcase
    end
endmodule

// File: rtl/afae_level_cmp.sv
module afae_level_cmp #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 7,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] word_cnt,
    input  logic [OFS_W-1:0] ofs_lo,
    input  logic [OFS_W-1:0] ofs_hi,
    output logic             level_flag,
    output logic             half_flag
);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] lo_lim;
    logic [CNT_W-1:0] hi_lim;

    assign lo_lim = CNT_W'(ofs_lo);
    assign hi_lim = DEPTH_V - CNT_W'(ofs_hi);

    always_comb begin
        level_flag = (word_cnt <= lo_lim) || (word_cnt >= hi_lim);
        half_flag  = (word_cnt >= HALF_V);
    end
endmodule

// File: rtl/afae_flag_ctrl.sv
module afae_flag_ctrl #(
    parameter int DEPTH   = 256,
    parameter int OFS_W   = 7,
    parameter int DEF_OFS = 32,
    parameter int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en_n,
    input  logic             load_stb,
    input  logic [OFS_W-1:0] din_lo,
    input  logic [CNT_W-1:0] word_cnt,
    output logic             level_flag,
    output logic             half_flag,
    output logic             wr_block
);
    logic [OFS_W-1:0] ofs_lo;
    logic [OFS_W-1:0] ofs_hi;

    afae_prog_fsm #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en_n(prog_en_n),
        .load_stb (load_stb),
        .din      (din_lo),
        .ofs_lo   (ofs_lo),
        .ofs_hi   (ofs_hi),
        .wr_block (wr_block)
    );

    afae_level_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_cmp (
        .word_cnt  (word_cnt),
        .ofs_lo    (ofs_lo),
        .ofs_hi    (ofs_hi),
        .level_flag(level_flag),
        .half_flag (half_flag)
    );
endmodule

// File: rtl/afae_flag_chk.sv
module afae_flag_chk #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 7,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_en_n,
    input logic             load_stb,
    input logic [OFS_W-1:0] din_lo,
    input logic [CNT_W-1:0] word_cnt,
    input logic             level_flag,
    input logic             half_flag,
    input logic             wr_block
);
    logic seen_prog;
    logic locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_prog <= 1'b0;
            locked    <= 1'b0;
        end else if (load_stb) begin
            if (prog_en_n || seen_prog) locked <= 1'b1;
            if (!prog_en_n)             seen_prog <= 1'b1;
        end
    end

    // R6: inhibit only on a programming strobe
    assert_block_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> (load_stb && !prog_en_n));

    // R4 / R5: closed window never inhibits
    assert_locked_no_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !wr_block);

    // R2: first programming strobe is always inhibited
    assert_first_prog_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_prog && !locked && load_stb && !prog_en_n) |-> wr_block);

    // R7 / R1: empty and full ends always flagged
    assert_empty_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == '0) |-> level_flag);
    assert_full_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt == CNT_W'(DEPTH)) |-> level_flag);

    // R8: half flag follows count
    assert_half_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        half_flag == (word_cnt >= CNT_W'(DEPTH / 2)));

    // R9: offsets move only on strobes
    assert_flag_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(word_cnt) && !$past(load_stb)) |-> $stable(level_flag));
endmodule

bind afae_flag_ctrl afae_flag_chk #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en_n (prog_en_n),
    .load_stb  (load_stb),
    .din_lo    (din_lo),
    .word_cnt  (word_cnt),
    .level_flag(level_flag),
    .half_flag (half_flag),
    .wr_block  (wr_block)
);

// File: tb/test_afae_flag_ctrl.sv
`timescale 1ns/1ps
module test_afae_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en_n = 1'b1;
    logic       load_stb = 1'b0;
    logic [6:0] din_lo = '0;
    logic [8:0] word_cnt = '0;
    logic       level_flag, half_flag, wr_block;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    afae_flag_ctrl i_afae_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .prog_en_n(prog_en_n), .load_stb(load_stb),
        .din_lo(din_lo), .word_cnt(word_cnt),
        .level_flag(level_flag), .half_flag(half_flag), .wr_block(wr_block)
    );

    // scenario: [6:0] v1, [7] prog1, [8] prog2, [15:9] v2, [22:16] exp lo, [29:23] exp hi
    localparam int NSC = 5;
    localparam logic [29:0] SCEN [NSC] = '{
        {7'd32,  7'd32,  7'd0,   1'b0, 1'b0, 7'd0},
        {7'd10,  7'd10,  7'd0,   1'b0, 1'b1, 7'd10},
        {7'd100, 7'd5,   7'd100, 1'b1, 1'b1, 7'd5},
        {7'd0,   7'd127, 7'd0,   1'b1, 1'b1, 7'd127},
        {7'd0,   7'd0,   7'd0,   1'b0, 1'b1, 7'd0}
    };

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp_v, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; load_stb = 1'b0; prog_en_n = 1'b1; word_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // one strobe; wr_block checked in its cycle
    task automatic strobe(input logic pen_n, input logic [6:0] v, input logic exp_blk, input string req);
        @(negedge clk);
        load_stb = 1'b1; prog_en_n = pen_n; din_lo = v;
        #1 chk(req, int'(wr_block), int'(exp_blk));
        @(negedge clk);
        load_stb = 1'b0; prog_en_n = 1'b1;
        #1;
    endtask

    task automatic check_flags(input int c, input int ex, input int ey, input string req);
        word_cnt = 9'(c);
        #0.5;
        chk(req, int'(level_flag), int'((c <= ex) || (c >= 256 - ey)));
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 flag", int'(level_flag), 1);
        chk("R1 half", int'(half_flag), 0);
        chk("R1 blk", int'(wr_block), 0);

        // table-driven programming scenarios with full count sweep
        for (int s = 0; s < NSC; s++) begin
            logic [29:0] e;
            int ex, ey;
            e  = SCEN[s];
            ex = int'(e[22:16]);
            ey = int'(e[29:23]);
            do_reset();
            if (e[7])  strobe(1'b0, e[6:0],  1'b1, "R2 first prog blocked");
            if (e[8])  strobe(1'b0, e[15:9], 1'b1, "R3 second prog blocked");
            strobe(1'b1, 7'd99, 1'b0, "R4 closing strobe");
            @(negedge clk);
            for (int c = 0; c <= 256; c++) begin
                check_flags(c, ex, ey, "R7 level");
                chk("R8 half", int'(half_flag), int'(c >= 128));
                chk("R6 idle blk", int'(wr_block), 0);
            end
            word_cnt = '0;
        end

        // R10: default transition points
        do_reset();
        check_flags(32, 32, 32, "R10 at 32");
        chk("R10 32 high", int'(level_flag), 1);
        check_flags(33, 32, 32, "R10 at 33");
        chk("R10 33 low", int'(level_flag), 0);
        check_flags(223, 32, 32, "R10 at 223");
        chk("R10 223 low", int'(level_flag), 0);
        check_flags(224, 32, 32, "R10 at 224");
        chk("R10 224 high", int'(level_flag), 1);

        // R9: prog low without strobe is ignored, then first strobe still loads both
        do_reset();
        @(negedge clk);
        prog_en_n = 1'b0; din_lo = 7'd3;
        repeat (4) @(negedge clk);
        #1 chk("R9 no strobe no blk", int'(wr_block), 0);
        check_flags(33, 32, 32, "R9 offsets unchanged");
        prog_en_n = 1'b1;
        strobe(1'b0, 7'd20, 1'b1, "R9 first prog still blocked");
        check_flags(20, 20, 20, "R9 R2 lo loaded");
        check_flags(21, 20, 20, "R9 R2 lo edge");
        check_flags(236, 20, 20, "R9 R2 hi loaded");
        check_flags(235, 20, 20, "R9 R2 hi edge");

        // R5: third programming strobe not blocked, no change
        strobe(1'b0, 7'd50, 1'b1, "R3 second prog");
        check_flags(21, 20, 50, "R3 lo kept");
        check_flags(206, 20, 50, "R3 hi rewritten");
        check_flags(205, 20, 50, "R3 hi edge");
        strobe(1'b0, 7'd90, 1'b0, "R5 third prog not blocked");
        check_flags(21, 20, 50, "R5 lo unchanged");
        check_flags(205, 20, 50, "R5 hi unchanged");

        // R4: after a normal write, programming attempts ignored
        do_reset();
        strobe(1'b1, 7'd7, 1'b0, "R4 normal write");
        strobe(1'b0, 7'd7, 1'b0, "R4 late prog not blocked");
        check_flags(33, 32, 32, "R4 lo default");
        check_flags(223, 32, 32, "R4 hi default");
        // R4: close after one programming strobe keeps high offset
        do_reset();
        strobe(1'b0, 7'd12, 1'b1, "R2 prog");
        strobe(1'b1, 7'd60, 1'b0, "R4 close after first");
        strobe(1'b0, 7'd60, 1'b0, "R4 prog after close");
        check_flags(244, 12, 12, "R4 hi unchanged");
        check_flags(243, 12, 12, "R4 hi edge");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule